// File: doc/BRIEF.md
# Packet Stream Statistics with Coherent Snapshot

This block observes two packet streams, one outbound and one inbound, and keeps running totals of packet boundaries on each of them. On the outbound side it counts packet starts and packet ends. On the inbound side it counts packet starts, packet ends, and packet ends that carry an error mark. A marker counts only on a beat where the stream's valid and ready are both high. Each total is `CNT_W` bits wide, 64 by default.

A host reaches the totals through a 32-bit register port that uses word addressing. Each total appears as two words, a low half and a high half. Reading the two halves at different times could mix two different counts. To prevent that, the host sets a freeze bit in the control word. On the rising edge of that bit, every live total is copied into a shadow register in a single clock. While the bit stays set, register reads return the shadows and the live totals keep counting. Clearing the bit makes reads show the live totals again.

A second control bit clears all totals. It acts only at the moment it is written and always reads back as zero. A typical use is to clear the totals after checking a burst of traffic, so the next run starts from zero.

Top module: `pkt_stat_snap`

## Requirements
- R1: An active-low synchronous reset sets every live total, every shadow, the freeze bit and the read data register to zero.
- R2: An outbound start total increments on a clock where tx_valid, tx_ready and tx_sop are all 1. An outbound end total increments on a clock where tx_valid, tx_ready and tx_eop are all 1. The start total reads at word 8 (low half) and word 9 (high half). The end total reads at words 10 and 11.
- R3: Inbound start and end totals follow the same rule using the rx_* inputs. The start total reads at words 14 and 15. The end total reads at words 16 and 17.
- R4: The inbound error total increments on a clock where rx_valid, rx_ready, rx_eop and rx_err are all 1. It reads at words 18 and 19.
- R5: Control word 0 holds the freeze bit at bit 6. Writing word 0 loads bit 6 from host_wdata[6]. Reading word 0 returns the freeze bit at bit 6 and zero in every other bit.
- R6: When the freeze bit goes from 0 to 1, every shadow takes the live value held just before that clock, not including any increment in the same clock. While the bit is 1, reads of total words return the shadows and the live totals keep counting. While the bit is 0, reads return the live totals.
- R7: Writing word 0 with bit 0 set clears every live total and every shadow at the next edge. The clear wins over any increment or capture in the same clock. Bit 0 always reads back as 0.
- R8: Totals wrap modulo 2^CNT_W with no saturation. Any bit at or above CNT_W reads as zero.
- R9: Reads of any word other than 0, 8–11 and 14–19 return zero. Writes to total words change nothing.
- R10: Read data appears on host_rdata one clock after the clock that samples host_rd. It holds its value until the next read. A read and a write in the same clock return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Outbound beat valid |
| tx_ready | input | 1 | Outbound beat accepted |
| tx_sop | input | 1 | Outbound beat starts a packet |
| tx_eop | input | 1 | Outbound beat ends a packet |
| rx_valid | input | 1 | Inbound beat valid |
| rx_ready | input | 1 | Inbound beat accepted |
| rx_sop | input | 1 | Inbound beat starts a packet |
| rx_eop | input | 1 | Inbound beat ends a packet |
| rx_err | input | 1 | Inbound packet-end beat carries an error |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | ADDR_W | Word address (byte offset / 4) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |

## Verification
The counting is tried with several kinds of traffic. One is multi-beat packets with stalled beats, which shows that only accepted beats count. Another is single-beat packets where start and end share a beat, which shows the two totals are independent. A third is markers on beats that are valid but not ready, or ready but not valid, and these must leave the totals unchanged. Inbound packets mix clean and error-marked ends, which separates the error total from the end total. A freeze request and a clear request are each written on the same clock as a counted beat, which shows that capture takes the value from before the increment and that a clear wins over the increment. A long single-beat run pushes a narrow total past its wrap point.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

    localparam int NUM_CNT   = 5;
    localparam int REG_W     = 32;
    localparam int CTRL_WORD = 0;
    localparam int SNAP_BIT  = 6;
    localparam int CLR_BIT   = 0;

    typedef enum logic [2:0] {
        CNT_TX_SOP = 3'd0,
        CNT_TX_EOP = 3'd1,
        CNT_RX_SOP = 3'd2,
        CNT_RX_EOP = 3'd3,
        CNT_RX_ERR = 3'd4
    } cnt_id_e;

    // word address of the low half of each total; high half is the next word
    function automatic int cnt_lo_word(input int k);
        case (k)
            0:       return 8;
            1:       return 10;
            2:       return 14;
            3:       return 16;
            default: return 18;
        endcase
    endfunction

    function automatic logic word_is_mapped(input int unsigned w);
        return (w == 0) || (w >= 8 && w <= 11) || (w >= 14 && w <= 19);
    endfunction

endpackage

// File: rtl/pstat_ctr.sv
module pstat_ctr #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    input  logic         cap_i,
    output logic [W-1:0] live_o,
    output logic [W-1:0] shad_o
);

    typedef struct packed {
        logic [W-1:0] live;
        logic [W-1:0] shad;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.live = '0;
            st_d.shad = '0;
        end else begin
            if (cap_i) st_d.shad = st_q.live;
            if (inc_i) st_d.live = st_q.live + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_o = st_q.live;
    assign shad_o = st_q.shad;

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (live_o == '0) && (shad_o == '0));

    assert_count_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i) |=> live_o == $past(live_o) + W'(1));

    assert_count_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(live_o));

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cap_i) |=> shad_o == $past(live_o));

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !cap_i) |=> $stable(shad_o));

endmodule

// File: rtl/pstat_ctrl.sv
module pstat_ctrl
    import pstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic             snap_o,
    output logic             clr_o,
    output logic             cap_o
);

    typedef struct packed {
        logic snap;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.snap = wdata_i[SNAP_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_o = st_q.snap;
    assign clr_o  = wr_i & wdata_i[CLR_BIT];
    assign cap_o  = wr_i & wdata_i[SNAP_BIT] & ~st_q.snap;

    assert_cap_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |-> (!snap_o ##1 snap_o));

    assert_snap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(snap_o));

endmodule

// File: rtl/pkt_stat_snap.sv
module pkt_stat_snap
    import pstat_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic              tx_ready,
    input  logic              tx_sop,
    input  logic              tx_eop,
    input  logic              rx_valid,
    input  logic              rx_ready,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic              rx_err,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata
);

    localparam int EXT_W = 2 * REG_W;

    typedef struct packed {
        logic [REG_W-1:0] rdata;
    } top_st_t;

    top_st_t            st_d, st_q;
    logic [NUM_CNT-1:0] inc;
    logic               tx_fire, rx_fire;
    logic               ctrl_wr, snap, clr, cap;
    logic [CNT_W-1:0]   live_w [NUM_CNT];
    logic [CNT_W-1:0]   shad_w [NUM_CNT];
    logic [EXT_W-1:0]   live_ext [NUM_CNT];
    logic [EXT_W-1:0]   shad_ext [NUM_CNT];
    logic [EXT_W-1:0]   sel;
    logic [REG_W-1:0]   rd_val;

    // beat qualification
    assign tx_fire = tx_valid & tx_ready;
    assign rx_fire = rx_valid & rx_ready;

    always_comb begin
        inc             = '0;
        inc[CNT_TX_SOP] = tx_fire & tx_sop;
        inc[CNT_TX_EOP] = tx_fire & tx_eop;
        inc[CNT_RX_SOP] = rx_fire & rx_sop;
        inc[CNT_RX_EOP] = rx_fire & rx_eop;
        inc[CNT_RX_ERR] = rx_fire & rx_eop & rx_err;
    end

    assign ctrl_wr = host_wr && (host_addr == ADDR_W'(CTRL_WORD));

    pstat_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctrl_wr),
        .wdata_i (host_wdata),
        .snap_o  (snap),
        .clr_o   (clr),
        .cap_o   (cap)
    );

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_ctr
        pstat_ctr #(.W(CNT_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_i  (inc[k]),
            .clr_i  (clr),
            .cap_i  (cap),
            .live_o (live_w[k]),
            .shad_o (shad_w[k])
        );
        assign live_ext[k] = EXT_W'(live_w[k]);
        assign shad_ext[k] = EXT_W'(shad_w[k]);
    end

    // register decode
    always_comb begin
        rd_val = '0;
        sel    = '0;
        if (host_addr == ADDR_W'(CTRL_WORD)) rd_val[SNAP_BIT] = snap;
        for (int k = 0; k < NUM_CNT; k++) begin
            sel = snap ? shad_ext[k] : live_ext[k];
            if (host_addr == ADDR_W'(cnt_lo_word(k)))     rd_val = sel[REG_W-1:0];
            if (host_addr == ADDR_W'(cnt_lo_word(k) + 1)) rd_val = sel[EXT_W-1:REG_W];
        end
    end

    always_comb begin
        st_d = st_q;
        if (host_rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> host_rdata == '0);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !word_is_mapped(32'(host_addr))) |=> host_rdata == '0);

    assert_ctrl_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_W'(CTRL_WORD)) |=>
            (host_rdata & ~(REG_W'(1) << SNAP_BIT)) == '0);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

    assert_frozen_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && snap && host_addr == ADDR_W'(cnt_lo_word(0))) |=>
            host_rdata == $past(shad_ext[0][REG_W-1:0]));

endmodule

// File: tb/pkt_stat_snap_tb_top.sv
module pkt_stat_snap_tb_top;

    localparam int  TB_CNT_W = 8;
    localparam int  AW       = 6;
    localparam time TCLK     = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_valid = 0, tx_ready = 0, tx_sop = 0, tx_eop = 0;
    logic          rx_valid = 0, rx_ready = 0, rx_sop = 0, rx_eop = 0, rx_err = 0;
    logic          host_wr = 0, host_rd = 0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(TCLK/2) clk = ~clk;

    pkt_stat_snap #(.CNT_W(TB_CNT_W), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_sop(rx_sop), .rx_eop(rx_eop),
        .rx_err(rx_err),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    // ---------------- reference model ----------------
    longint unsigned m_live [5];
    longint unsigned m_shad [5];
    bit              m_snap;
    logic [31:0]     m_rdata;
    bit              started = 0;
    int              lo_word [5] = '{8, 10, 14, 16, 18};
    longint unsigned mask = (64'd1 << TB_CNT_W) - 1;

    function automatic logic [31:0] model_read(input int a);
        longint unsigned v;
        if (a == 0) return m_snap ? 32'h40 : 32'h0;
        for (int k = 0; k < 5; k++) begin
            v = m_snap ? m_shad[k] : m_live[k];
            if (a == lo_word[k])     return v[31:0];
            if (a == lo_word[k] + 1) return v[63:32];
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        bit wctl, clr, cap;
        bit ev [5];
        if (!rst_n) begin
            for (int k = 0; k < 5; k++) begin m_live[k] = 0; m_shad[k] = 0; end
            m_snap  = 0;
            m_rdata = '0;
        end else begin
            if (host_rd) m_rdata = model_read(int'(host_addr));
            wctl  = host_wr && host_addr == 0;
            clr   = wctl && host_wdata[0];
            cap   = wctl && host_wdata[6] && !m_snap;
            ev[0] = tx_valid && tx_ready && tx_sop;
            ev[1] = tx_valid && tx_ready && tx_eop;
            ev[2] = rx_valid && rx_ready && rx_sop;
            ev[3] = rx_valid && rx_ready && rx_eop;
            ev[4] = rx_valid && rx_ready && rx_eop && rx_err;
            for (int k = 0; k < 5; k++) begin
                if (clr) begin
                    m_live[k] = 0; m_shad[k] = 0;
                end else begin
                    if (cap)   m_shad[k] = m_live[k];
                    if (ev[k]) m_live[k] = (m_live[k] + 1) & mask;
                end
            end
            if (wctl) m_snap = host_wdata[6];
        end
        started = 1;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // per-clock comparison against the model (R10 timing)
    always @(negedge clk) begin
        if (started && !finished) chk("R10 model", host_rdata, m_rdata);
    end

    // ---------------- stimulus tasks ----------------
    task automatic beat(input logic [3:0] t, input logic [4:0] r);
        @(negedge clk);
        {tx_valid, tx_ready, tx_sop, tx_eop}         = t;
        {rx_valid, rx_ready, rx_sop, rx_eop, rx_err} = r;
        @(negedge clk);
        {tx_valid, tx_ready, tx_sop, tx_eop}         = '0;
        {rx_valid, rx_ready, rx_sop, rx_eop, rx_err} = '0;
    endtask

    task automatic hwrite(input int a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hread(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1; host_addr = AW'(a);
        @(negedge clk);
        host_rd = 0;
        chk(tag, host_rdata, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: everything reads zero out of reset
        hread(0, 32'h0, "R1 ctrl");
        for (int w = 8; w < 20; w++) if (w < 12 || w > 13) hread(w, 32'h0, "R1 total");

        // R2 R3 R4: 16 packets with stalls and noise
        for (int i = 0; i < 16; i++) begin
            beat(4'b1110, 5'b11100);
            beat(4'b1001, 5'b10011);          // valid without ready: ignored
            beat(4'b0111, 5'b01110);          // ready without valid: ignored
            beat(4'b1101, {4'b1101, (i % 5 == 0)});
        end
        hread(8,  32'd16, "R2 tx sop lo");
        hread(9,  32'd0,  "R2 tx sop hi");
        hread(10, 32'd16, "R2 tx eop lo");
        hread(14, 32'd16, "R3 rx sop lo");
        hread(16, 32'd16, "R3 rx eop lo");
        hread(18, 32'd4,  "R4 rx err lo");
        hread(19, 32'd0,  "R4 rx err hi");

        // R5 R6: freeze, keep counting, release
        hwrite(0, 32'h40);
        hread(0, 32'h40, "R5 ctrl freeze bit");
        for (int i = 0; i < 5; i++) beat(4'b1111, 5'b0);
        hread(8, 32'd16, "R6 frozen tx sop");
        hwrite(0, 32'h0);
        hread(0, 32'h0,  "R5 ctrl released");
        hread(8, 32'd21, "R6 live tx sop");

        // R6: capture on the same clock as an increment
        @(negedge clk);
        host_wr = 1; host_addr = 0; host_wdata = 32'h40;
        {tx_valid, tx_ready, tx_sop, tx_eop} = 4'b1110;
        @(negedge clk);
        host_wr = 0; {tx_valid, tx_ready, tx_sop, tx_eop} = '0;
        hread(8, 32'd21, "R6 capture before increment");
        hwrite(0, 32'h0);
        hread(8, 32'd22, "R6 live after capture");

        // R7: clear wins over a same-clock increment
        @(negedge clk);
        host_wr = 1; host_addr = 0; host_wdata = 32'h1;
        {tx_valid, tx_ready, tx_sop, tx_eop} = 4'b1111;
        {rx_valid, rx_ready, rx_sop, rx_eop, rx_err} = 5'b11111;
        @(negedge clk);
        host_wr = 0;
        {tx_valid, tx_ready, tx_sop, tx_eop} = '0;
        {rx_valid, rx_ready, rx_sop, rx_eop, rx_err} = '0;
        hread(8,  32'd0, "R7 tx sop cleared");
        hread(18, 32'd0, "R7 rx err cleared");
        hread(0,  32'd0, "R7 clear bit self-clears");

        // R9: writes to totals ignored, unmapped reads zero
        beat(4'b1111, 5'b11111);
        beat(4'b1111, 5'b11111);
        hwrite(8, 32'hFFFF_FFFF);
        hwrite(18, 32'h1234_5678);
        hread(8,  32'd2, "R9 write to total ignored");
        hread(18, 32'd2, "R9 write to err ignored");
        hread(5,  32'd0, "R9 unmapped 5");
        hread(12, 32'd0, "R9 unmapped 12");
        hread(20, 32'd0, "R9 unmapped 20");
        hread(63, 32'd0, "R9 unmapped 63");

        // R10: data holds between reads
        hread(16, 32'd2, "R10 read");
        repeat (4) @(negedge clk);
        chk("R10 hold", host_rdata, 32'd2);

        // R8: wrap of a narrow total
        for (int i = 0; i < 260; i++) beat(4'b1111, 5'b0);
        hread(8,  32'd6, "R8 wrapped lo");
        hread(9,  32'd0, "R8 hi above width");
        hread(10, 32'd6, "R8 eop wrapped");

        // R1: reset again with non-zero state
        hwrite(0, 32'h40);
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        hread(0, 32'h0, "R1 ctrl after reset");
        hread(8, 32'h0, "R1 total after reset");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule